// File: doc/BRIEF.md
# Serial Configuration Register File

This block holds sixteen 8-bit configuration registers for a camera front end. A host writes them one command at a time over a three-wire serial link: an active-low select that frames the command, a serial clock and a data line. All three wires are brought into the master clock domain and sampled there, so the master clock must be running while a command is sent. The registers feed the gain and offset circuits that follow. Four gain registers sit at addresses 0h-3h, and the four offset registers at 4h-7h form pairs with them: offset n goes with gain n. The output black level is at 8h and control register 0 is at 9h.

A command is 13 bits, sent most significant bit first. The first bit is the direction (0 = write, 1 = read), the next four bits are the address and the last eight bits are the data. Nothing is stored while select is low. When select rises, the frame controller checks the frame. A write with at least 13 bits is committed, using the last 13 bits shifted. Every other frame is dropped. The frame controller has three states: ST_IDLE, ST_SHIFT and ST_COMMIT. There are four transitions: T_START (ST_IDLE to ST_SHIFT when select falls), T_ACCEPT (ST_SHIFT to ST_COMMIT when select rises on a valid write), T_REJECT (ST_SHIFT to ST_IDLE when select rises on any other frame) and T_DONE (ST_COMMIT to ST_IDLE after the one-cycle write strobe).

Bit 0 of control register 0 turns on offset auto-calibration. While it is set, the host can no longer write the offset registers, and a separate calibration port owns them. Bit 1 selects four-colour mode. When bit 1 is clear, the block is in single-channel mode, and one gain/offset pair serves every pixel.

Top module: `cfg_serial_regfile`

## Requirements
- R1: After reset the gain registers (0h-3h) read 40h, the offset registers (4h-7h) read 00h, the black level register (8h) reads 10h, and all other registers, including control register 0 (9h), read 00h.
- R2: After reset `four_colour_on` is 0, which is single-channel mode. The output follows bit 1 of register 9h after every later write.
- R3: A frame of 13 bits, sent MSB first as {direction=0, address[3:0], data[7:0]}, writes the data to the addressed register. The write lands within 8 master clocks after select rises.
- R4: A frame with fewer than 13 bits changes no register.
- R5: A frame longer than 13 bits acts as a 13-bit frame made of its last 13 bits.
- R6: A frame whose direction bit is 1 changes no register.
- R7: While bit 0 of register 9h is 1 (`autocal_on`), a host write to addresses 4h-7h changes nothing. Host writes to every other address still land.
- R8: A pulse on `cal_we` writes `cal_data` into offset register `cal_idx` (address 4h+`cal_idx`) only while auto-calibration is on. While it is off, the pulse has no effect.
- R9: A calibration write and a host commit in the same cycle both take effect.
- R10: No register changes while select is still low, even after all bits of a frame have been shifted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_n | input | 1 | Serial frame select, active low |
| sclk | input | 1 | Serial clock; data is taken on its rising edge |
| sdata | input | 1 | Serial data, MSB first |
| cal_we | input | 1 | Calibration write strobe |
| cal_idx | input | 2 | Offset register index for the calibration write |
| cal_data | input | 8 | Calibration offset value |
| reg_image | output | 128 | All registers; register k is held in bits [8k+7:8k] |
| autocal_on | output | 1 | Bit 0 of register 9h |
| four_colour_on | output | 1 | Bit 1 of register 9h |

## Verification
Two write paths can act in the same cycle: the host commit strobe and the calibration port. The bench provokes this by holding `cal_we` high for the whole of a serial frame, so the calibration write is still active in the cycle of the commit whatever the synchroniser delay is. In the first case, the host writes gain 2 while the calibration port writes offset 2. In the second case, the host clears auto-calibration while the calibration port keeps writing offset 1. The results are judged from the final register image: both writes must be present. The calibration value must remain after the enable is cleared, and a later calibration pulse must be ignored.

// File: rtl/cfg_pkg.sv
package cfg_pkg;

    localparam int CFG_DATA_W = 8;
    localparam int CFG_ADDR_W = 4;

    // Frame controller states
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SHIFT  = 2'd1,
        ST_COMMIT = 2'd2
    } frame_state_e;

    // Reset value of register idx; offsets and control fall into the zero branch
    function automatic logic [31:0] cfg_default(
        input int          idx,
        input int          pairs,
        input int          black_addr,
        input logic [31:0] gain_d,
        input logic [31:0] black_d
    );
        if (idx < pairs)        return gain_d;
        if (idx == black_addr)  return black_d;
        return 32'd0;
    endfunction

endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
    parameter int              WIDTH   = 3,
    parameter int              STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);

    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int k = 0; k < STAGES; k++) pipe[k] <= RST_VAL;
        end else begin
            pipe[0] <= din;
            for (int k = 1; k < STAGES; k++) pipe[k] <= pipe[k-1];
        end
    end

    assign dout = pipe[STAGES-1];

endmodule

// File: rtl/cfg_frame_shifter.sv
module cfg_frame_shifter
    import cfg_pkg::*;
#(
    parameter int ADDR_W = CFG_ADDR_W,
    parameter int DATA_W = CFG_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n_s,
    input  logic              sclk_s,
    input  logic              sdata_s,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    localparam int FRAME_BITS = 1 + ADDR_W + DATA_W;
    localparam int CNT_W      = $clog2(FRAME_BITS + 1);
    localparam logic [CNT_W-1:0] FULL = CNT_W'(FRAME_BITS);

    frame_state_e           state, nxt;
    logic                   sclk_q;
    logic                   sclk_rise;
    logic [FRAME_BITS-1:0]  shreg;
    logic [CNT_W-1:0]       cnt;
    logic                   frame_ok;

    assign sclk_rise = sclk_s & ~sclk_q;
    // complete frame with direction bit 0 (write)
    assign frame_ok  = (cnt == FULL) && (shreg[FRAME_BITS-1] == 1'b0);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Transitions: T_START, T_ACCEPT, T_REJECT, T_DONE
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   if (!cs_n_s) nxt = ST_SHIFT;                      // T_START
            ST_SHIFT:  if (cs_n_s)  nxt = frame_ok ? ST_COMMIT : ST_IDLE; // T_ACCEPT / T_REJECT
            ST_COMMIT: nxt = ST_IDLE;                                     // T_DONE
            default:   nxt = ST_IDLE;
        endcase
    end

    // Shift path: bit count saturates, shift keeps only the newest bits
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            shreg  <= '0;
            cnt    <= '0;
        end else begin
            sclk_q <= sclk_s;
            if (state == ST_IDLE) begin
                cnt <= '0;
            end else if (state == ST_SHIFT && sclk_rise) begin
                shreg <= {shreg[FRAME_BITS-2:0], sdata_s};
                if (cnt != FULL) cnt <= cnt + 1'b1;
            end
        end
    end

    // Outputs
    always_comb begin
        wr_en   = (state == ST_COMMIT);
        wr_addr = shreg[DATA_W +: ADDR_W];
        wr_data = shreg[DATA_W-1:0];
    end

endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
    import cfg_pkg::*;
#(
    parameter int              DATA_W      = CFG_DATA_W,
    parameter int              ADDR_W      = CFG_ADDR_W,
    parameter int              NUM_PAIRS   = 4,
    parameter int              BLACK_ADDR  = 8,
    parameter int              CTRL_ADDR   = 9,
    parameter int              AUTOCAL_BIT = 0,
    parameter logic [DATA_W-1:0] GAIN_DFLT = 8'h40,
    parameter logic [DATA_W-1:0] BLACK_DFLT = 8'h10,
    localparam int             NREG        = 1 << ADDR_W,
    localparam int             IDX_W       = $clog2(NUM_PAIRS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [ADDR_W-1:0]      wr_addr,
    input  logic [DATA_W-1:0]      wr_data,
    input  logic                   cal_we,
    input  logic [IDX_W-1:0]       cal_idx,
    input  logic [DATA_W-1:0]      cal_data,
    output logic [NREG*DATA_W-1:0] image
);

    localparam int OFFS_BASE = NUM_PAIRS;

    logic autocal;
    assign autocal = image[CTRL_ADDR*DATA_W + AUTOCAL_BIT];

    for (genvar gi = 0; gi < NREG; gi++) begin : g_reg
        localparam logic [DATA_W-1:0] RST =
            DATA_W'(cfg_default(gi, NUM_PAIRS, BLACK_ADDR, 32'(GAIN_DFLT), 32'(BLACK_DFLT)));
        localparam bit IS_OFFS = (gi >= OFFS_BASE) && (gi < OFFS_BASE + NUM_PAIRS);

        logic [DATA_W-1:0] q;
        logic              host_hit;
        logic              cal_hit;

        // host path is locked out of the offset slots while calibration owns them
        assign host_hit = wr_en && (wr_addr == ADDR_W'(gi)) && !(IS_OFFS && autocal);

        if (IS_OFFS) begin : g_cal
            assign cal_hit = cal_we && autocal && (cal_idx == IDX_W'(gi - OFFS_BASE));
        end else begin : g_nocal
            assign cal_hit = 1'b0;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        q <= RST;
            else if (host_hit) q <= wr_data;
            else if (cal_hit)  q <= cal_data;
        end

        assign image[gi*DATA_W +: DATA_W] = q;
    end

endmodule

// File: rtl/cfg_serial_regfile.sv
module cfg_serial_regfile
    import cfg_pkg::*;
#(
    parameter int              DATA_W      = CFG_DATA_W,
    parameter int              ADDR_W      = CFG_ADDR_W,
    parameter int              NUM_PAIRS   = 4,
    parameter int              BLACK_ADDR  = 8,
    parameter int              CTRL_ADDR   = 9,
    parameter int              AUTOCAL_BIT = 0,
    parameter int              FOURCOL_BIT = 1,
    parameter int              SYNC_STAGES = 2,
    parameter logic [DATA_W-1:0] GAIN_DFLT = 8'h40,
    parameter logic [DATA_W-1:0] BLACK_DFLT = 8'h10,
    localparam int             NREG        = 1 << ADDR_W,
    localparam int             IDX_W       = $clog2(NUM_PAIRS)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   sel_n,
    input  logic                   sclk,
    input  logic                   sdata,
    input  logic                   cal_we,
    input  logic [IDX_W-1:0]       cal_idx,
    input  logic [DATA_W-1:0]      cal_data,
    output logic [NREG*DATA_W-1:0] reg_image,
    output logic                   autocal_on,
    output logic                   four_colour_on
);

    logic [2:0]        pins_s;
    logic              host_we;
    logic [ADDR_W-1:0] host_addr;
    logic [DATA_W-1:0] host_data;

    cfg_sync #(
        .WIDTH   (3),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (3'b100)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({sel_n, sclk, sdata}),
        .dout  (pins_s)
    );

    cfg_frame_shifter #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_frame (
        .clk     (clk),
        .rst_n   (rst_n),
        .cs_n_s  (pins_s[2]),
        .sclk_s  (pins_s[1]),
        .sdata_s (pins_s[0]),
        .wr_en   (host_we),
        .wr_addr (host_addr),
        .wr_data (host_data)
    );

    cfg_reg_bank #(
        .DATA_W      (DATA_W),
        .ADDR_W      (ADDR_W),
        .NUM_PAIRS   (NUM_PAIRS),
        .BLACK_ADDR  (BLACK_ADDR),
        .CTRL_ADDR   (CTRL_ADDR),
        .AUTOCAL_BIT (AUTOCAL_BIT),
        .GAIN_DFLT   (GAIN_DFLT),
        .BLACK_DFLT  (BLACK_DFLT)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (host_we),
        .wr_addr  (host_addr),
        .wr_data  (host_data),
        .cal_we   (cal_we),
        .cal_idx  (cal_idx),
        .cal_data (cal_data),
        .image    (reg_image)
    );

    assign autocal_on     = reg_image[CTRL_ADDR*DATA_W + AUTOCAL_BIT];
    assign four_colour_on = reg_image[CTRL_ADDR*DATA_W + FOURCOL_BIT];

endmodule

// File: rtl/cfg_serial_regfile_chk.sv
module cfg_serial_regfile_chk
    import cfg_pkg::*;
#(
    parameter int              DATA_W      = CFG_DATA_W,
    parameter int              ADDR_W      = CFG_ADDR_W,
    parameter int              NUM_PAIRS   = 4,
    parameter int              BLACK_ADDR  = 8,
    parameter logic [DATA_W-1:0] GAIN_DFLT = 8'h40,
    parameter logic [DATA_W-1:0] BLACK_DFLT = 8'h10,
    localparam int             NREG        = 1 << ADDR_W,
    localparam int             IDX_W       = $clog2(NUM_PAIRS)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NREG*DATA_W-1:0] reg_image,
    input logic                   autocal_on,
    input logic                   host_we,
    input logic [ADDR_W-1:0]      host_addr,
    input logic [DATA_W-1:0]      host_data,
    input logic                   cal_we,
    input logic [IDX_W-1:0]       cal_idx,
    input logic [DATA_W-1:0]      cal_data
);

    localparam int OFFS_BASE = NUM_PAIRS;

    logic [NREG*DATA_W-1:0] dflt_image;
    logic                   fresh;
    logic                   host_in_offs;

    always_comb begin
        for (int k = 0; k < NREG; k++)
            dflt_image[k*DATA_W +: DATA_W] =
                DATA_W'(cfg_default(k, NUM_PAIRS, BLACK_ADDR, 32'(GAIN_DFLT), 32'(BLACK_DFLT)));
    end

    assign host_in_offs = (32'(host_addr) >= OFFS_BASE) && (32'(host_addr) < OFFS_BASE + NUM_PAIRS);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) fresh <= 1'b1;
        else        fresh <= 1'b0;
    end

    // R1: first cycle out of reset shows the default image
    a_r1_reset_defaults: assert property (@(posedge clk) disable iff (!rst_n)
        fresh |-> reg_image == dflt_image);

    // R3: an unlocked host commit lands in the addressed slot
    a_r3_host_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        host_we && !(autocal_on && host_in_offs)
        |=> reg_image[$past(host_addr)*DATA_W +: DATA_W] == $past(host_data));

    // R7: locked offset write leaves the image untouched
    a_r7_offset_locked: assert property (@(posedge clk) disable iff (!rst_n)
        host_we && autocal_on && host_in_offs && !cal_we |=> $stable(reg_image));

    // R8: calibration write lands while enabled
    a_r8_cal_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
        cal_we && autocal_on
        |=> reg_image[(OFFS_BASE + 32'($past(cal_idx)))*DATA_W +: DATA_W] == $past(cal_data));

    // R8: calibration write ignored while disabled
    a_r8_cal_ignored_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        cal_we && !autocal_on && !host_we |=> $stable(reg_image));

    // R10 / R4: without a commit or calibration strobe nothing moves
    a_r10_quiet_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        !host_we && !cal_we |=> $stable(reg_image));

endmodule

bind cfg_serial_regfile cfg_serial_regfile_chk #(
    .DATA_W     (DATA_W),
    .ADDR_W     (ADDR_W),
    .NUM_PAIRS  (NUM_PAIRS),
    .BLACK_ADDR (BLACK_ADDR),
    .GAIN_DFLT  (GAIN_DFLT),
    .BLACK_DFLT (BLACK_DFLT)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .reg_image  (reg_image),
    .autocal_on (autocal_on),
    .host_we    (host_we),
    .host_addr  (host_addr),
    .host_data  (host_data),
    .cal_we     (cal_we),
    .cal_idx    (cal_idx),
    .cal_data   (cal_data)
);

// File: tb/test_cfg_serial_regfile.sv
module test_cfg_serial_regfile;

    logic         clk = 1'b0;
    logic         rst_n = 1'b1;
    logic         sel_n = 1'b1;
    logic         sclk = 1'b0;
    logic         sdata = 1'b0;
    logic         cal_we = 1'b0;
    logic [1:0]   cal_idx = '0;
    logic [7:0]   cal_data = '0;
    logic [127:0] reg_image;
    logic         autocal_on;
    logic         four_colour_on;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0] m [16];

    always #5 clk = ~clk;

    cfg_serial_regfile i_cfg_serial_regfile (
        .clk            (clk),
        .rst_n          (rst_n),
        .sel_n          (sel_n),
        .sclk           (sclk),
        .sdata          (sdata),
        .cal_we         (cal_we),
        .cal_idx        (cal_idx),
        .cal_data       (cal_data),
        .reg_image      (reg_image),
        .autocal_on     (autocal_on),
        .four_colour_on (four_colour_on)
    );

    task automatic check_bit(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s flag actual %0b expected %0b", tag, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        for (int r = 0; r < 16; r++) begin
            checks++;
            if (reg_image[r*8 +: 8] !== m[r]) begin
                errors++;
                $display("FAIL %s reg %0d actual %02h expected %02h", tag, r, reg_image[r*8 +: 8], m[r]);
            end
        end
        check_bit({tag, " autocal"}, autocal_on, m[9][0]);
        check_bit({tag, " fourcol"}, four_colour_on, m[9][1]);
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    // sends the low nbits of bits, MSB first
    task automatic send_frame(input int nbits, input logic [31:0] bits, input bit mid_check);
        @(negedge clk) sel_n = 1'b0;
        wait_clk(4);
        for (int i = nbits - 1; i >= 0; i--) begin
            sdata = bits[i];
            wait_clk(4);
            sclk = 1'b1;
            wait_clk(4);
            sclk = 1'b0;
        end
        wait_clk(8);
        if (mid_check) check_all("R10");
        sel_n = 1'b1;
        wait_clk(8);
    endtask

    function automatic bit locked(input int a);
        return (a >= 4) && (a <= 7) && m[9][0];
    endfunction

    task automatic host_write(input int a, input logic [7:0] d, input bit mid_check);
        send_frame(13, {19'd0, 1'b0, 4'(a), d}, mid_check);
        if (!locked(a)) m[a] = d;
    endtask

    task automatic cal_pulse(input int idx, input logic [7:0] d);
        @(negedge clk);
        cal_we = 1'b1; cal_idx = 2'(idx); cal_data = d;
        @(negedge clk);
        cal_we = 1'b0;
        if (m[9][0]) m[4+idx] = d;
        wait_clk(2);
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int r = 0; r < 16; r++) m[r] = 8'h00;
        for (int r = 0; r < 4; r++) m[r] = 8'h40;
        m[8] = 8'h10;

        #2 rst_n = 1'b0;
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(2);
        check_all("R1");
        check_bit("R2 single channel", four_colour_on, 1'b0);

        // R3 sweep over every address; 9h gets C3h, turning on calibration and four-colour
        for (int a = 0; a < 16; a++) begin
            host_write(a, 8'((a * 17) ^ 8'h5A), (a == 3));
            check_all("R3");
        end
        check_bit("R2 four colour", four_colour_on, 1'b1);
        check_bit("R7 autocal set", autocal_on, 1'b1);

        // R7 sweep with calibration on (9h left alone)
        for (int a = 0; a < 16; a++) begin
            if (a != 9) begin
                host_write(a, ~m[a], 1'b0);
                check_all("R7");
            end
        end

        // R8 calibration writes while enabled
        for (int i = 0; i < 4; i++) begin
            cal_pulse(i, 8'hA0 + 8'(i));
            check_all("R8 on");
        end

        // R9 host gain 2 and calibration offset 2 overlap
        @(negedge clk);
        cal_we = 1'b1; cal_idx = 2'd2; cal_data = 8'h77;
        host_write(2, 8'h3C, 1'b0);
        cal_we = 1'b0;
        m[6] = 8'h77;
        wait_clk(2);
        check_all("R9 gain+cal");

        // R9 host clears calibration while the calibration port keeps writing
        @(negedge clk);
        cal_we = 1'b1; cal_idx = 2'd1; cal_data = 8'h66;
        m[5] = 8'h66;
        host_write(9, 8'h00, 1'b0);
        cal_we = 1'b0;
        wait_clk(2);
        check_all("R9 ctrl+cal");

        // R8 calibration ignored while disabled
        for (int i = 0; i < 4; i++) begin
            cal_pulse(i, 8'h11 + 8'(i));
            check_all("R8 off");
        end

        // R4 short frames aimed at address 0
        for (int n = 1; n < 13; n++) begin
            send_frame(n, {19'd0, 1'b0, 4'd0, 8'hE7}, 1'b0);
            check_all("R4");
        end

        // R5 long frames: leading ones, then a valid write
        for (int n = 14; n <= 20; n++) begin
            send_frame(n, (32'hFFFF_FFFF << 13) | {19'd0, 1'b0, 4'(n - 14), 8'(n * 3)}, 1'b0);
            m[n-14] = 8'(n * 3);
            check_all("R5");
        end

        // R6 read-direction frames
        for (int a = 0; a < 16; a += 5) begin
            send_frame(13, {19'd0, 1'b1, 4'(a), 8'h99}, 1'b0);
            check_all("R6");
        end

        // R2 mode bit toggled alone
        host_write(9, 8'h02, 1'b0);
        check_all("R2 set");
        host_write(9, 8'h00, 1'b1);
        check_all("R2 clear");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule